// File: doc/BRIEF.md
# Sticky Error Status and Interrupt Request Block

This block gathers error events from a set of transmit channels, a set of receive channels and a clock-recovery loop phase detector. Every event lands in its own bit of one status byte. The bit stays set until software reads that byte, and the read clears it. Two interrupt request lines come out of the block. The transmit request follows the latched transmit-channel bits. The receive request follows the latched receive-channel bits together with the phase-limit bit. Each class has its own enable input. An enable gates only the request line, never the latching.

A small synchronous bus gives the processor access. It carries an address, write data, a write strobe, a read strobe and a registered read-data output. A shadow register keeps the byte of the most recent bus write to any address, so diagnostics can confirm that data passes over the bus intact. The error status byte sits at address 0x3C and the shadow byte at 0x3B. Read data appears one clock after the read strobe.

Each status bit is a two-state machine. The states are CLEAR and HELD. The transitions are:
- CLEAR to HELD on an event (EV_SET).
- HELD to CLEAR on a clearing read with no event in the same cycle (RD_CLR).
- HELD to HELD on any other cycle (KEEP).
- CLEAR to CLEAR when there is no event (IDLE).

Top module: `errstat_top`

## Requirements
- R1: After reset the following are all 0: every status bit, both interrupt requests, the shadow register and the read data.
- R2: A read at address 0x3C returns the status byte as it stood before the read, on `bus_rdata_o` one cycle after the strobe. The same read clears every bit whose event is not active in that cycle.
- R3: A status bit, once set, stays set across any number of cycles until a read at 0x3C clears it.
- R4: An event that arrives in the same cycle as a clearing read does not appear in that read's data. The bit is set after the read, and the next read returns it.
- R5: The status byte layout is:
  - bit 7: phase-limit error;
  - bits 6:4: receive channels 3, 2, 1, from high bit to low bit;
  - bits 3:1: transmit channels 3, 2, 1, from high bit to low bit;
  - bit 0: always reads 0.

  Channel k is input bit k-1 of the event vectors.
- R6: `tx_irq_o` is 1 exactly while `tx_irq_en_i` is 1 and at least one transmit bit is set.
- R7: `rx_irq_o` is 1 exactly while `rx_irq_en_i` is 1 with a receive bit set, or while `pll_irq_en_i` is 1 with the phase-limit bit set.
- R8: The enables have no effect on latching. An event with its enable at 0 still sets its bit and is returned by the next read.
- R9: Every bus write, at any address, loads its data into the shadow register. A read at 0x3B returns the shadow register without clearing any status bit.
- R10: A write to 0x3C leaves the status byte unchanged. A read at any other address clears nothing. A read at an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Registered read data, valid one cycle after the read strobe |
| tx_err_i | input | 3 | Transmit channel error events, bit k-1 is channel k |
| rx_err_i | input | 3 | Receive channel error events, bit k-1 is channel k |
| pll_lim_i | input | 1 | Phase detector reached its upper or lower error limit |
| tx_irq_en_i | input | 1 | Transmit class interrupt enable |
| rx_irq_en_i | input | 1 | Receive class interrupt enable |
| pll_irq_en_i | input | 1 | Phase-limit class interrupt enable |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
Suppose a status bit machine is stuck in HELD or CLEAR, or is wired to the wrong position. The read data shows the wrong bit one cycle after the next status read. The interrupt lines show the fault on the cycle right after the event edge. A clear that is lost or comes too early shows up on the second of two back-to-back reads. An event swallowed by a coincident read shows up there too. A shadow register that does not track writes shows up on the first read of 0x3B after a write. The sweep drives every event pattern under every enable combination, so a misrouted class or enable cannot stay hidden.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    typedef enum logic {
        ES_CLEAR = 1'b0,
        ES_HELD  = 1'b1
    } es_state_t;

endpackage

// File: rtl/errstat_cell.sv
module errstat_cell
    import errstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o
);

    es_state_t state_q;
    es_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ES_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_CLEAR: if (set_i)  state_d = ES_HELD;                 // EV_SET
            ES_HELD:  if (clr_i && !set_i) state_d = ES_CLEAR;       // RD_CLR
        endcase
    end

    always_comb held_o = (state_q == ES_HELD);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !clr_i) |=> held_o);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o);
    // R2
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !held_o);

endmodule

// File: rtl/errstat_irq.sv
module errstat_irq #(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] tx_bits_i,
    input  logic [N_CH-1:0] rx_bits_i,
    input  logic            pll_bit_i,
    input  logic            tx_en_i,
    input  logic            rx_en_i,
    input  logic            pll_en_i,
    output logic            tx_irq_o,
    output logic            rx_irq_o
);

    logic rx_from_ch;
    logic rx_from_pll;

    always_comb begin
        tx_irq_o    = tx_en_i && (|tx_bits_i);
        rx_from_ch  = rx_en_i && (|rx_bits_i);
        rx_from_pll = pll_en_i && pll_bit_i;
        rx_irq_o    = rx_from_ch || rx_from_pll;
    end

    // R6
    tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bits_i == '0) |-> !tx_irq_o);
    // R7
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_bits_i == '0) && !pll_bit_i) |-> !rx_irq_o);

endmodule

// File: rtl/errstat_shadow.sv
module errstat_shadow #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] shadow_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow_o <= '0;
        else if (wr_i) shadow_o <= wdata_i;
    end

    // R9
    shadow_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (shadow_o == $past(wdata_i)));
    // R9
    shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(shadow_o));

endmodule

// File: rtl/errstat_top.sv
module errstat_top #(
    parameter int          N_CH      = 3,
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [7:0]  STAT_ADDR = 8'h3C,
    parameter logic [7:0]  SHAD_ADDR = 8'h3B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    input  logic            bus_wr_i,
    input  logic            bus_rd_i,
    output logic [DW-1:0]   bus_rdata_o,
    input  logic [N_CH-1:0] tx_err_i,
    input  logic [N_CH-1:0] rx_err_i,
    input  logic            pll_lim_i,
    input  logic            tx_irq_en_i,
    input  logic            rx_irq_en_i,
    input  logic            pll_irq_en_i,
    output logic            tx_irq_o,
    output logic            rx_irq_o
);

    localparam int NB      = 2 * N_CH + 1;
    localparam int PLL_POS = DW - 1;

    logic [NB-1:0] ev_vec;
    logic [NB-1:0] held_vec;
    logic [DW-1:0] stat_vec;
    logic [DW-1:0] shadow;
    logic [DW-1:0] rd_mux;
    logic          hit_stat;
    logic          hit_shad;
    logic          clr;

    always_comb begin
        hit_stat = (bus_addr_i == STAT_ADDR[AW-1:0]);
        hit_shad = (bus_addr_i == SHAD_ADDR[AW-1:0]);
        clr      = bus_rd_i && hit_stat;
        ev_vec   = {pll_lim_i, rx_err_i, tx_err_i};
    end

    for (genvar k = 0; k < NB; k++) begin : g_cell
        errstat_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev_vec[k]),
            .clr_i  (clr),
            .held_o (held_vec[k])
        );
    end

    always_comb begin
        stat_vec              = '0;
        stat_vec[N_CH:1]      = held_vec[N_CH-1:0];
        stat_vec[2*N_CH:N_CH+1] = held_vec[2*N_CH-1:N_CH];
        stat_vec[PLL_POS]     = held_vec[NB-1];
    end

    errstat_shadow #(.DW(DW)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr_i),
        .wdata_i  (bus_wdata_i),
        .shadow_o (shadow)
    );

    errstat_irq #(.N_CH(N_CH)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_bits_i (held_vec[N_CH-1:0]),
        .rx_bits_i (held_vec[2*N_CH-1:N_CH]),
        .pll_bit_i (held_vec[NB-1]),
        .tx_en_i   (tx_irq_en_i),
        .rx_en_i   (rx_irq_en_i),
        .pll_en_i  (pll_irq_en_i),
        .tx_irq_o  (tx_irq_o),
        .rx_irq_o  (rx_irq_o)
    );

    always_comb begin
        if (hit_stat)      rd_mux = stat_vec;
        else if (hit_shad) rd_mux = shadow;
        else               rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_mux;
    end

    // R2
    read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bus_rdata_o == $past(stat_vec)));
    // R10
    other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !hit_stat) |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));
    // R5
    bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_o[0] || !$past(clr));
    // R7
    pll_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_lim_i && pll_irq_en_i) |=> (rx_irq_o || !pll_irq_en_i));

endmodule

// File: tb/errstat_top_tb_top.sv
`timescale 1ns/1ps
module errstat_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic [2:0] tx_err = '0;
    logic [2:0] rx_err = '0;
    logic       pll = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       pll_en = 1'b0;
    logic       tx_irq;
    logic       rx_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    errstat_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata),
        .tx_err_i(tx_err), .rx_err_i(rx_err), .pll_lim_i(pll),
        .tx_irq_en_i(tx_en), .rx_irq_en_i(rx_en), .pll_irq_en_i(pll_en),
        .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge, removed at the next
    task automatic step(input logic [6:0] ev, input logic r, input logic w,
                        input logic [7:0] a, input logic [7:0] d);
        tx_err = ev[2:0]; rx_err = ev[5:3]; pll = ev[6];
        rd = r; wr = w; addr = a; wdata = d;
        @(negedge clk);
        tx_err = '0; rx_err = '0; pll = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    function automatic logic [7:0] layout(input logic [6:0] p);
        return {p[6], p[5:3], p[2:0], 1'b0};
    endfunction

    initial begin
        logic [7:0] e;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {6'd0, tx_irq, rx_irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        step(7'd0, 1'b1, 1'b0, 8'h3B, 8'h00);
        chk("R1 shadow", rdata, 8'h00);
        step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R1 status", rdata, 8'h00);

        // R5 R6 R7 R8 exhaustive sweep over patterns and enables
        for (int en = 0; en < 8; en++) begin
            tx_en = en[0]; rx_en = en[1]; pll_en = en[2];
            for (int p = 0; p < 128; p++) begin
                logic [6:0] pv;
                logic xt;
                logic xr;
                pv = p[6:0];
                step(pv, 1'b0, 1'b0, 8'h00, 8'h00);
                xt = en[0] && (pv[2:0] != 0);
                xr = (en[1] && (pv[5:3] != 0)) || (en[2] && pv[6]);
                chk("R6 tx_irq", {7'd0, tx_irq}, {7'd0, xt});
                chk("R7 rx_irq", {7'd0, rx_irq}, {7'd0, xr});
                step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
                chk("R5 R8 layout", rdata, layout(pv));
                chk("R2 irq after clear", {6'd0, tx_irq, rx_irq}, 8'h00);
            end
        end
        tx_en = 1'b1; rx_en = 1'b1; pll_en = 1'b1;

        // R3 sticky accumulate across idle cycles
        step(7'b0000101, 1'b0, 1'b0, 8'h00, 8'h00);
        repeat (20) @(negedge clk);
        step(7'b1010000, 1'b0, 1'b0, 8'h00, 8'h00);
        chk("R3 irq held", {6'd0, tx_irq, rx_irq}, 8'h03);
        step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R3 accumulated", rdata, layout(7'b1010101));
        step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R2 second read zero", rdata, 8'h00);

        // R4 event coincident with clearing read
        step(7'b0000010, 1'b0, 1'b0, 8'h00, 8'h00);
        step(7'b0100000, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R4 read sees old", rdata, layout(7'b0000010));
        chk("R4 rx irq survives", {7'd0, rx_irq}, 8'h01);
        chk("R4 tx irq cleared", {7'd0, tx_irq}, 8'h00);
        step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R4 late event kept", rdata, layout(7'b0100000));

        // R9 shadow on various addresses
        for (int i = 0; i < 16; i++) begin
            e = 8'(i * 37 + 5);
            step(7'd0, 1'b0, 1'b1, 8'(i * 17), e);
            step(7'd0, 1'b1, 1'b0, 8'h3B, 8'h00);
            chk("R9 shadow", rdata, e);
        end

        // R10 write to status, read elsewhere, unmapped read
        step(7'b1001001, 1'b0, 1'b0, 8'h00, 8'h00);
        step(7'd0, 1'b0, 1'b1, 8'h3C, 8'h00);
        step(7'd0, 1'b1, 1'b0, 8'h3B, 8'h00);
        chk("R9 write to 3C shadowed", rdata, 8'h00);
        step(7'd0, 1'b1, 1'b0, 8'h55, 8'h00);
        chk("R10 unmapped read", rdata, 8'h00);
        chk("R10 irq kept", {6'd0, tx_irq, rx_irq}, 8'h03);
        step(7'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R10 status untouched", rdata, layout(7'b1001001));
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule